// File: doc/BRIEF.md
# Register-to-Register ALU Execute Unit

This block is the execute stage for operations that stay among the registers of an 8-bit accumulator machine. That machine has an accumulator A, two index registers X and Y, and four status flags: negative, overflow, zero and carry. Each cycle the stage takes an operation code, the present register and flag values, and returns the next register and flag values. It also returns a write enable for each register and for each flag.

The set covers 23 operations: setting overflow, inverting carry, copies between the index registers, swaps, AND/XOR/OR of A with an index register, add and subtract with carry, and compares between any ordered pair of the three registers. Swaps exchange both registers in one step. Compares only change flags. Results are registered, so they appear one clock after the code is presented. Nothing here fetches opcodes, touches memory or the stack, or does decimal adjust.

Top module: `rr_exec_unit`

## Requirements
- R1: While reset is asserted (rst_n low), every output is zero, including all write enables.
- R2: The outputs for a code presented before a rising clock edge appear after that edge and hold until the next edge. Codes presented on back-to-back cycles give back-to-back results.
- R3: The flag bus is ordered bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. Code 0 sets V. Code 1 inverts C. For each of these two codes only that one flag's write enable is raised.
- R4: Code 2 copies X into Y and code 3 copies Y into X. Each sets N from bit 7 and Z from zero-ness of the copied value, and leaves C and V unwritten.
- R5: Code 4 swaps A and X, code 5 swaps A and Y, code 6 swaps X and Y. Both registers are enabled for write and no flag is written.
- R6: Codes 7 and 8 write A AND X and A AND Y to A. Codes 9 and 10 write A XOR X and A XOR Y. Codes 11 and 12 write A OR X and A OR Y. Each sets only N and Z, from the result.
- R7: Codes 13 and 14 write A + X + C and A + Y + C to A. C is the carry out, V is signed overflow, and N and Z come from the result.
- R8: Codes 15 and 16 write A − X − (1−C) and A − Y − (1−C) to A. C is set when no borrow occurs, V is signed overflow, and N and Z come from the result.
- R9: Codes 17 to 22 compare the ordered pairs A:X, A:Y, X:A, X:Y, Y:A and Y:X. C = first ≥ second (unsigned), Z = equal, N = bit 7 of first − second. No register and not V is written.
- R10: Codes 23 to 31 are no-ops. All write enables are low and the outputs repeat the inputs.
- R11: Any register or flag whose write enable is low outputs the value it had on the input side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code, 0 to 31 |
| a_in | input | 8 | Present accumulator |
| x_in | input | 8 | Present X register |
| y_in | input | 8 | Present Y register |
| flags_in | input | 4 | Present flags {N,V,Z,C} |
| a_out | output | 8 | Next accumulator |
| x_out | output | 8 | Next X register |
| y_out | output | 8 | Next Y register |
| flags_out | output | 4 | Next flags {N,V,Z,C} |
| a_we | output | 1 | Accumulator written |
| x_we | output | 1 | X written |
| y_we | output | 1 | Y written |
| flag_we | output | 4 | Per-flag write enables {N,V,Z,C} |

## Verification
The bench targets the carry and overflow edges of add and subtract: 0x7F+1, 0xFF+1, 0x80−1, and subtract with carry clear. A design that feeds the borrow with the wrong polarity, or computes V from the raw operand rather than its complement, gives a result off by one or a wrong V. Compares are run with equal, greater, lesser and sign-crossing pairs. An operand order mix-up shows as an inverted C, and a compare that writes back shows as a raised register enable. Swaps are checked for both halves of the exchange, because a design that updates one register before reading it would copy instead of swap. The unused codes are checked to make sure no enable leaks.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;

    localparam int unsigned DW     = 8;
    localparam int unsigned OP_W   = 5;
    localparam int unsigned FLAG_W = 4;

    localparam int unsigned FLG_N = 3;
    localparam int unsigned FLG_V = 2;
    localparam int unsigned FLG_Z = 1;
    localparam int unsigned FLG_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_SET_OVF   = 5'd0,
        OP_FLIP_CY   = 5'd1,
        OP_COPY_XY   = 5'd2,
        OP_COPY_YX   = 5'd3,
        OP_XCHG_AX   = 5'd4,
        OP_XCHG_AY   = 5'd5,
        OP_XCHG_XY   = 5'd6,
        OP_AND_X     = 5'd7,
        OP_AND_Y     = 5'd8,
        OP_XOR_X     = 5'd9,
        OP_XOR_Y     = 5'd10,
        OP_OR_X      = 5'd11,
        OP_OR_Y      = 5'd12,
        OP_ADD_X     = 5'd13,
        OP_ADD_Y     = 5'd14,
        OP_SUB_X     = 5'd15,
        OP_SUB_Y     = 5'd16,
        OP_CMP_AX    = 5'd17,
        OP_CMP_AY    = 5'd18,
        OP_CMP_XA    = 5'd19,
        OP_CMP_XY    = 5'd20,
        OP_CMP_YA    = 5'd21,
        OP_CMP_YX    = 5'd22
    } op_e;

    typedef enum logic [1:0] {
        REG_A = 2'd0,
        REG_X = 2'd1,
        REG_Y = 2'd2
    } reg_e;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_FLAG  = 3'd1,
        CLS_MOVE  = 3'd2,
        CLS_SWAP  = 3'd3,
        CLS_LOGIC = 3'd4,
        CLS_ARITH = 3'd5,
        CLS_CMP   = 3'd6
    } cls_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_XOR = 2'd1,
        LF_OR  = 2'd2
    } lfn_e;

    // Decoded control: src_l is the first operand / destination,
    // src_r the second operand / source.
    typedef struct packed {
        cls_e cls;
        reg_e src_l;
        reg_e src_r;
        lfn_e lfn;
        logic sub;
        logic set_v;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0]     a;
        logic [DW-1:0]     x;
        logic [DW-1:0]     y;
        logic [FLAG_W-1:0] flags;
        logic              a_we;
        logic              x_we;
        logic              y_we;
        logic [FLAG_W-1:0] flag_we;
    } result_t;

endpackage

// File: rtl/rr_exec_decode.sv
module rr_exec_decode
    import rr_exec_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output ctrl_t           ctl
);

    op_e op;

    always_comb begin
        op        = op_e'(op_sel);
        ctl       = '0;
        ctl.cls   = CLS_NONE;
        ctl.src_l = REG_A;
        ctl.src_r = REG_A;
        ctl.lfn   = LF_AND;
        case (op)
            OP_SET_OVF: begin ctl.cls = CLS_FLAG; ctl.set_v = 1'b1; end
            OP_FLIP_CY: begin ctl.cls = CLS_FLAG; ctl.set_v = 1'b0; end
            OP_COPY_XY: begin ctl.cls = CLS_MOVE; ctl.src_l = REG_Y; ctl.src_r = REG_X; end
            OP_COPY_YX: begin ctl.cls = CLS_MOVE; ctl.src_l = REG_X; ctl.src_r = REG_Y; end
            OP_XCHG_AX: begin ctl.cls = CLS_SWAP; ctl.src_l = REG_A; ctl.src_r = REG_X; end
            OP_XCHG_AY: begin ctl.cls = CLS_SWAP; ctl.src_l = REG_A; ctl.src_r = REG_Y; end
            OP_XCHG_XY: begin ctl.cls = CLS_SWAP; ctl.src_l = REG_X; ctl.src_r = REG_Y; end
            OP_AND_X:   begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_X; ctl.lfn = LF_AND; end
            OP_AND_Y:   begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_Y; ctl.lfn = LF_AND; end
            OP_XOR_X:   begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_X; ctl.lfn = LF_XOR; end
            OP_XOR_Y:   begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_Y; ctl.lfn = LF_XOR; end
            OP_OR_X:    begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_X; ctl.lfn = LF_OR; end
            OP_OR_Y:    begin ctl.cls = CLS_LOGIC; ctl.src_r = REG_Y; ctl.lfn = LF_OR; end
            OP_ADD_X:   begin ctl.cls = CLS_ARITH; ctl.src_r = REG_X; end
            OP_ADD_Y:   begin ctl.cls = CLS_ARITH; ctl.src_r = REG_Y; end
            OP_SUB_X:   begin ctl.cls = CLS_ARITH; ctl.src_r = REG_X; ctl.sub = 1'b1; end
            OP_SUB_Y:   begin ctl.cls = CLS_ARITH; ctl.src_r = REG_Y; ctl.sub = 1'b1; end
            OP_CMP_AX:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_A; ctl.src_r = REG_X; ctl.sub = 1'b1; end
            OP_CMP_AY:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_A; ctl.src_r = REG_Y; ctl.sub = 1'b1; end
            OP_CMP_XA:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_X; ctl.src_r = REG_A; ctl.sub = 1'b1; end
            OP_CMP_XY:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_X; ctl.src_r = REG_Y; ctl.sub = 1'b1; end
            OP_CMP_YA:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_Y; ctl.src_r = REG_A; ctl.sub = 1'b1; end
            OP_CMP_YX:  begin ctl.cls = CLS_CMP; ctl.src_l = REG_Y; ctl.src_r = REG_X; ctl.sub = 1'b1; end
            default:    ctl.cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/rr_exec_addsub.sv
module rr_exec_addsub
    import rr_exec_pkg::*;
(
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);

    localparam int unsigned MSB = DW - 1;

    logic [DW-1:0] rhs_eff;
    logic [DW:0]   wide;

    always_comb begin
        rhs_eff = sub ? ~rhs : rhs;
        wide    = {1'b0, lhs} + {1'b0, rhs_eff} + {{DW{1'b0}}, cin};
        sum     = wide[DW-1:0];
        cout    = wide[DW];
        ovf     = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
    end

endmodule

// File: rtl/rr_exec_logic.sv
module rr_exec_logic
    import rr_exec_pkg::*;
(
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  lfn_e          lfn,
    output logic [DW-1:0] res
);

    always_comb begin
        case (lfn)
            LF_AND:  res = lhs & rhs;
            LF_XOR:  res = lhs ^ rhs;
            LF_OR:   res = lhs | rhs;
            default: res = lhs;
        endcase
    end

endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
    import rr_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DW-1:0]     a_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     y_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DW-1:0]     a_out,
    output logic [DW-1:0]     x_out,
    output logic [DW-1:0]     y_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              a_we,
    output logic              x_we,
    output logic              y_we,
    output logic [FLAG_W-1:0] flag_we
);

    localparam int unsigned NPORT = 2;
    localparam int unsigned MSB   = DW - 1;

    ctrl_t         ctl;
    logic [DW-1:0] opnd_l;
    logic [DW-1:0] opnd_r;
    logic [DW-1:0] as_sum;
    logic          as_cout;
    logic          as_ovf;
    logic          as_cin;
    logic [DW-1:0] lg_res;

    logic [NPORT-1:0] wen;
    reg_e             wreg [NPORT];
    logic [DW-1:0]    wval [NPORT];

    result_t res_d;
    result_t res_q;

    rr_exec_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    always_comb begin
        case (ctl.src_l)
            REG_X:   opnd_l = x_in;
            REG_Y:   opnd_l = y_in;
            default: opnd_l = a_in;
        endcase
        case (ctl.src_r)
            REG_X:   opnd_r = x_in;
            REG_Y:   opnd_r = y_in;
            default: opnd_r = a_in;
        endcase
    end

    assign as_cin = (ctl.cls == CLS_CMP) ? 1'b1 : flags_in[FLG_C];

    rr_exec_addsub u_addsub (
        .lhs  (opnd_l),
        .rhs  (opnd_r),
        .sub  (ctl.sub),
        .cin  (as_cin),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    rr_exec_logic u_logic (
        .lhs (opnd_l),
        .rhs (opnd_r),
        .lfn (ctl.lfn),
        .res (lg_res)
    );

    always_comb begin
        res_d       = '0;
        res_d.a     = a_in;
        res_d.x     = x_in;
        res_d.y     = y_in;
        res_d.flags = flags_in;
        for (int p = 0; p < NPORT; p++) begin
            wen[p]  = 1'b0;
            wreg[p] = REG_A;
            wval[p] = '0;
        end

        case (ctl.cls)
            CLS_FLAG: begin
                if (ctl.set_v) begin
                    res_d.flags[FLG_V]   = 1'b1;
                    res_d.flag_we[FLG_V] = 1'b1;
                end else begin
                    res_d.flags[FLG_C]   = ~flags_in[FLG_C];
                    res_d.flag_we[FLG_C] = 1'b1;
                end
            end
            CLS_MOVE: begin
                wen[0]  = 1'b1;
                wreg[0] = ctl.src_l;
                wval[0] = opnd_r;
            end
            CLS_SWAP: begin
                wen     = '1;
                wreg[0] = ctl.src_l;
                wval[0] = opnd_r;
                wreg[1] = ctl.src_r;
                wval[1] = opnd_l;
            end
            CLS_LOGIC: begin
                wen[0]  = 1'b1;
                wreg[0] = REG_A;
                wval[0] = lg_res;
            end
            CLS_ARITH: begin
                wen[0]               = 1'b1;
                wreg[0]              = REG_A;
                wval[0]              = as_sum;
                res_d.flags[FLG_C]   = as_cout;
                res_d.flags[FLG_V]   = as_ovf;
                res_d.flag_we[FLG_C] = 1'b1;
                res_d.flag_we[FLG_V] = 1'b1;
            end
            CLS_CMP: begin
                res_d.flags[FLG_N]   = as_sum[MSB];
                res_d.flags[FLG_Z]   = (opnd_l == opnd_r);
                res_d.flags[FLG_C]   = as_cout;
                res_d.flag_we[FLG_N] = 1'b1;
                res_d.flag_we[FLG_Z] = 1'b1;
                res_d.flag_we[FLG_C] = 1'b1;
            end
            default: ;
        endcase

        // N and Z follow the value written, except for swaps
        if (wen[0] && ctl.cls != CLS_SWAP) begin
            res_d.flags[FLG_N]   = wval[0][MSB];
            res_d.flags[FLG_Z]   = (wval[0] == '0);
            res_d.flag_we[FLG_N] = 1'b1;
            res_d.flag_we[FLG_Z] = 1'b1;
        end

        for (int p = 0; p < NPORT; p++) begin
            if (wen[p]) begin
                case (wreg[p])
                    REG_X: begin res_d.x = wval[p]; res_d.x_we = 1'b1; end
                    REG_Y: begin res_d.y = wval[p]; res_d.y_we = 1'b1; end
                    default: begin res_d.a = wval[p]; res_d.a_we = 1'b1; end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign a_out     = res_q.a;
    assign x_out     = res_q.x;
    assign y_out     = res_q.y;
    assign flags_out = res_q.flags;
    assign a_we      = res_q.a_we;
    assign x_we      = res_q.x_we;
    assign y_we      = res_q.y_we;
    assign flag_we   = res_q.flag_we;

endmodule

// File: rtl/rr_exec_unit_chk.sv
module rr_exec_unit_chk
    import rr_exec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_sel,
    input logic [DW-1:0]     a_in,
    input logic [DW-1:0]     x_in,
    input logic [DW-1:0]     y_in,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DW-1:0]     a_out,
    input logic [DW-1:0]     x_out,
    input logic [DW-1:0]     y_out,
    input logic [FLAG_W-1:0] flags_out,
    input logic              a_we,
    input logic              x_we,
    input logic              y_we,
    input logic [FLAG_W-1:0] flag_we
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_we && !x_we && !y_we && flag_we == '0));

    // R3
    set_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd0) |=> (flags_out[FLG_V] && flag_we == 4'b0100));

    // R3
    flip_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd1) |=> (flags_out[FLG_C] != $past(flags_in[FLG_C]) && flag_we == 4'b0001));

    // R5
    swap_ax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd4) |=> (a_out == $past(x_in) && x_out == $past(a_in) && flag_we == '0));

    // R9
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 5'd17 && op_sel <= 5'd22) |=> (!a_we && !x_we && !y_we && !flag_we[FLG_V]));

    // R10
    unused_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 5'd22) |=> (!a_we && !x_we && !y_we && flag_we == '0));

    // R6
    a_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && flag_we[FLG_Z]) |-> (flags_out[FLG_Z] == (a_out == '0)));

    // R11
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a_we || a_out == $past(a_in)));

    // R11
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (y_we || y_out == $past(y_in)));

endmodule

bind rr_exec_unit rr_exec_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .a_in      (a_in),
    .x_in      (x_in),
    .y_in      (y_in),
    .flags_in  (flags_in),
    .a_out     (a_out),
    .x_out     (x_out),
    .y_out     (y_out),
    .flags_out (flags_out),
    .a_we      (a_we),
    .x_we      (x_we),
    .y_we      (y_we),
    .flag_we   (flag_we)
);

// File: tb/rr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module rr_exec_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] a_in = '0, x_in = '0, y_in = '0;
    logic [3:0] flags_in = '0;
    logic [7:0] a_out, x_out, y_out;
    logic [3:0] flags_out, flag_we;
    logic       a_we, x_we, y_we;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rr_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
        .a_in(a_in), .x_in(x_in), .y_in(y_in), .flags_in(flags_in),
        .a_out(a_out), .x_out(x_out), .y_out(y_out), .flags_out(flags_out),
        .a_we(a_we), .x_we(x_we), .y_we(y_we), .flag_we(flag_we)
    );

    // Independent model, flags {N,V,Z,C}
    function automatic logic [42:0] model(input logic [4:0] op, input logic [7:0] a,
                                           input logic [7:0] x, input logic [7:0] y,
                                           input logic [3:0] f);
        logic [7:0] ea, ex, ey, l, r, v;
        logic [3:0] ef, fw;
        logic       wa, wx, wy;
        logic [8:0] s;
        ea = a; ex = x; ey = y; ef = f; fw = '0; wa = 0; wx = 0; wy = 0;
        l = 0; r = 0; v = 0; s = 0;
        if (op == 0) begin ef[2] = 1; fw = 4'b0100; end
        else if (op == 1) begin ef[0] = ~f[0]; fw = 4'b0001; end
        else if (op == 2) begin ey = x; wy = 1; v = x; end
        else if (op == 3) begin ex = y; wx = 1; v = y; end
        else if (op == 4) begin ea = x; ex = a; wa = 1; wx = 1; end
        else if (op == 5) begin ea = y; ey = a; wa = 1; wy = 1; end
        else if (op == 6) begin ex = y; ey = x; wx = 1; wy = 1; end
        else if (op >= 7 && op <= 12) begin
            r = op[0] ? x : y;
            case (op)
                7, 8:    v = a & r;
                9, 10:   v = a ^ r;
                default: v = a | r;
            endcase
            ea = v; wa = 1;
        end else if (op >= 13 && op <= 16) begin
            r = (op == 13 || op == 15) ? x : y;
            if (op >= 15) r = ~r;
            s = {1'b0, a} + {1'b0, r} + {8'd0, f[0]};
            v = s[7:0]; ea = v; wa = 1;
            ef[0] = s[8];
            ef[2] = (a[7] == r[7]) && (v[7] != a[7]);
            fw = 4'b0101;
        end else if (op >= 17 && op <= 22) begin
            case (op)
                17: begin l = a; r = x; end
                18: begin l = a; r = y; end
                19: begin l = x; r = a; end
                20: begin l = x; r = y; end
                21: begin l = y; r = a; end
                default: begin l = y; r = x; end
            endcase
            s = {1'b0, l} - {1'b0, r};
            ef[3] = s[7]; ef[1] = (l == r); ef[0] = (l >= r);
            fw = 4'b1011;
        end
        if (op >= 2 && op <= 16 && !(op >= 4 && op <= 6)) begin
            ef[3] = v[7]; ef[1] = (v == 0); fw = fw | 4'b1010;
        end
        return {ea, ex, ey, ef, wa, wx, wy, fw};
    endfunction

    function automatic logic [42:0] got();
        return {a_out, x_out, y_out, flags_out, a_we, x_we, y_we, flag_we};
    endfunction

    task automatic cmp(input string tag, input logic [42:0] act, input logic [42:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] y, input logic [3:0] f);
        op_sel = op; a_in = a; x_in = x; y_in = y; flags_in = f;
    endtask

    // Drive at a falling edge, check at the next falling edge
    task automatic run_op(input string tag, input logic [4:0] op, input logic [7:0] a,
                          input logic [7:0] x, input logic [7:0] y, input logic [3:0] f);
        @(negedge clk);
        drive(op, a, x, y, f);
        @(negedge clk);
        cmp(tag, got(), model(op, a, x, y, f));
    endtask

    task automatic test_reset();
        @(negedge clk);
        drive(5'd13, 8'hFF, 8'h01, 8'h22, 4'hF);
        @(negedge clk);
        cmp("R1 reset outputs zero", got(), 43'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_flag_ops();
        run_op("R3 set V from clear", 5'd0, 8'h12, 8'h34, 8'h56, 4'b0000);
        run_op("R3 set V already set", 5'd0, 8'h12, 8'h34, 8'h56, 4'b1111);
        run_op("R3 flip C 0->1", 5'd1, 8'h00, 8'h00, 8'h00, 4'b1010);
        run_op("R3 flip C 1->0", 5'd1, 8'h00, 8'h00, 8'h00, 4'b0101);
    endtask

    task automatic test_transfers();
        run_op("R4 copy X to Y neg", 5'd2, 8'h11, 8'h80, 8'h33, 4'b0101);
        run_op("R4 copy Y to X zero", 5'd3, 8'h11, 8'h22, 8'h00, 4'b0100);
    endtask

    task automatic test_swaps();
        run_op("R5 swap A X", 5'd4, 8'hA5, 8'h5A, 8'h77, 4'b1001);
        run_op("R5 swap A Y", 5'd5, 8'h01, 8'h02, 8'h80, 4'b0110);
        run_op("R5 swap X Y", 5'd6, 8'h00, 8'hC3, 8'h3C, 4'b0000);
    endtask

    task automatic test_logic();
        run_op("R6 and X zero", 5'd7, 8'hF0, 8'h0F, 8'hFF, 4'b0101);
        run_op("R6 and Y", 5'd8, 8'hF0, 8'h0F, 8'h90, 4'b0000);
        run_op("R6 xor X", 5'd9, 8'hFF, 8'h0F, 8'h00, 4'b0000);
        run_op("R6 xor Y self-like", 5'd10, 8'h55, 8'h00, 8'h55, 4'b1000);
        run_op("R6 or X", 5'd11, 8'h01, 8'h80, 8'h00, 4'b0000);
        run_op("R6 or Y", 5'd12, 8'h00, 8'h00, 8'h00, 4'b0111);
    endtask

    task automatic test_add();
        run_op("R7 add X signed ovf", 5'd13, 8'h7F, 8'h01, 8'h00, 4'b0000);
        run_op("R7 add Y carry wrap", 5'd14, 8'hFF, 8'h00, 8'h01, 4'b0000);
        run_op("R7 add X with carry in", 5'd13, 8'h50, 8'h50, 8'h00, 4'b0001);
        run_op("R7 add Y neg ovf", 5'd14, 8'h80, 8'h00, 8'h80, 4'b0000);
    endtask

    task automatic test_sub();
        run_op("R8 sub X underflow", 5'd15, 8'h00, 8'h01, 8'h00, 4'b0001);
        run_op("R8 sub Y signed ovf", 5'd16, 8'h80, 8'h00, 8'h01, 4'b0001);
        run_op("R8 sub X borrow in", 5'd15, 8'h05, 8'h03, 8'h00, 4'b0000);
        run_op("R8 sub Y zero", 5'd16, 8'h42, 8'h00, 8'h42, 4'b0001);
    endtask

    task automatic test_compare();
        run_op("R9 cmp A:X equal", 5'd17, 8'h40, 8'h40, 8'h00, 4'b0100);
        run_op("R9 cmp A:Y less", 5'd18, 8'h01, 8'h00, 8'h02, 4'b0001);
        run_op("R9 cmp X:A sign cross", 5'd19, 8'h01, 8'h80, 8'h00, 4'b0000);
        run_op("R9 cmp X:Y greater", 5'd20, 8'h00, 8'hFF, 8'h00, 4'b0100);
        run_op("R9 cmp Y:A less", 5'd21, 8'hFF, 8'h00, 8'h10, 4'b0000);
        run_op("R9 cmp Y:X equal", 5'd22, 8'h00, 8'h99, 8'h99, 4'b0000);
    endtask

    task automatic test_unused();
        for (int c = 23; c < 32; c++) begin
            run_op("R10 unused code no-op", 5'(c), 8'hC1 + 8'(c), 8'h3E, 8'h7A, 4'(c));
        end
    endtask

    task automatic test_hold();
        run_op("R11 untouched regs pass through", 5'd7, 8'hAA, 8'h55, 8'hE7, 4'b0101);
        run_op("R11 flags pass through on swap", 5'd6, 8'h10, 8'h20, 8'h30, 4'b1111);
    endtask

    task automatic test_pipeline();
        @(negedge clk);
        drive(5'd13, 8'h10, 8'h20, 8'h00, 4'b0000);
        @(negedge clk);
        cmp("R2 back-to-back first", got(), model(5'd13, 8'h10, 8'h20, 8'h00, 4'b0000));
        drive(5'd4, 8'h01, 8'h02, 8'h03, 4'b0010);
        @(posedge clk);
        #1;
        cmp("R2 second result one edge later", got(), model(5'd4, 8'h01, 8'h02, 8'h03, 4'b0010));
        @(negedge clk);
        drive(5'd31, 8'h01, 8'h02, 8'h03, 4'b0010);
        #1;
        cmp("R2 output held between edges", got(), model(5'd4, 8'h01, 8'h02, 8'h03, 4'b0010));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        test_reset();
        test_flag_ops();
        test_transfers();
        test_swaps();
        test_logic();
        test_add();
        test_sub();
        test_compare();
        test_unused();
        test_hold();
        test_pipeline();
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule